// File: doc/BRIEF.md
# Bus Cycle Watchdog Timer

This block watches each processor bus cycle and flags a bus error when the cycle runs too long. A bus cycle starts on the first clock where the cycle strobe `cyc_i` is sampled high after being sampled low. From that point a timeout runs, and the cycle ends when `cyc_i` is sampled low again. If no acknowledge arrives before the timeout expires, `berr_o` goes high. It stays high until the strobe drops, so the bus master can end the stalled access.

The timeout is picked by a 3-bit select. A value N gives 128·2^N clocks, so the range runs from 128 to 16384 clocks. Time is counted by a free-running divide-by-16 prescaler that feeds a main down-counter. The timeout is therefore only resolved to 16 clocks. Its exact length in any one cycle depends on the prescaler phase at the start of that cycle.

Top module: `bus_cycle_wdog`

## Requirements
- R1: While `rst_ni` is low and on the first clock after reset is released, `berr_o` is low.
- R2: With `en_i` high, `cyc_i` held high and no acknowledge, `berr_o` stays low for every clock n < 128·2^N−15, where n counts rising edges after the start edge and N is `tsel_i` (0..7) at the start edge.
- R3: Under the same conditions, `berr_o` is high at every clock n ≥ 128·2^N. Because the prescaler ticks every 16 clocks and runs freely, the rise falls somewhere in the window 128·2^N−15 ≤ n ≤ 128·2^N.
- R4: Once high, `berr_o` stays high while `cyc_i` and `en_i` stay high. It is low one clock after `cyc_i` is sampled low.
- R5: An `ack_i` sampled high in an active cycle before `berr_o` rises stops the timer, and `berr_o` stays low for the rest of that cycle. If the acknowledge and the expiry fall on the same clock, the acknowledge wins.
- R6: `en_i` sampled low forces `berr_o` low on the next clock and clears the timer. A cycle whose start edge sees `en_i` low is not timed, even if `en_i` rises later in that cycle.
- R7: `tsel_i` is sampled only at the start edge. A change to it during a cycle does not alter that cycle's timeout.
- R8: After `cyc_i` drops, the next start edge reloads a full timeout. This holds even when only one idle clock separates the two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Watchdog enable |
| tsel_i | input | 3 | Timeout select N, timeout = 128·2^N clocks |
| cyc_i | input | 1 | Bus cycle strobe, high during a cycle |
| ack_i | input | 1 | Bus cycle acknowledge |
| berr_o | output | 1 | Bus error, held until the cycle ends |

## Verification
A wrong count load or a lost prescaler tick shows up as a bus error that lands outside the 16-clock window. This appears at most 16384 clocks after the start edge, which is why the largest select is exercised. A stuck timer state shows up within a clock of a strobe drop, an enable drop or an acknowledge, because `berr_o` stays high or rises when it must stay low. The reference model compares `berr_o` on every clock against a window derived from the latched select. It also runs cycles at different prescaler phases, so an off-by-one in the load value shifts the rise outside the window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned PRE_W      = 4;   // 16-clock resolution
  localparam int unsigned BASE_TICKS = 8;   // ticks at select 0
  localparam int unsigned MAX_TICKS  = BASE_TICKS << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_TICKS) + 1;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tick_o = &pre_q;

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_sel_dec.sv
module wdog_sel_dec #(
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned BASE_TICKS = 8
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] load_o
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(BASE_TICKS);

  always_comb load_o = BASE << sel_i;

  // R2
  always_comb load_nz_chk: assert (load_o != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cyc_i,
  input  logic             ack_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             berr_o
);
  logic             cyc_q, armed_q, berr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= 1'b0;
      armed_q <= 1'b0;
      berr_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cyc_q <= cyc_i;
      if (!cyc_i || !en_i) begin
        armed_q <= 1'b0;
        berr_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (!cyc_q) begin
        // cycle start: select latched here only
        armed_q <= 1'b1;
        berr_q  <= 1'b0;
        cnt_q   <= load_i;
      end else if (armed_q && ack_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (armed_q && tick_i) begin
        if (cnt_q == CNT_W'(1)) begin
          berr_q  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign berr_o = berr_q;

  // R4
  berr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (berr_q && cyc_i && cyc_q && en_i) |=> berr_q);
  // R4
  berr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |=> !berr_q);
  // R6
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !berr_q);
  // R5
  ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ack_i && cyc_i && cyc_q && en_i) |=> !berr_q);
  // R3
  rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!berr_q && !tick_i) |=> !berr_q);
endmodule

// File: rtl/bus_cycle_wdog.sv
module bus_cycle_wdog
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] tsel_i,
  input  logic       cyc_i,
  input  logic       ack_i,
  output logic       berr_o
);
  logic             tick;
  logic [CNT_W-1:0] load;

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  wdog_sel_dec #(
    .SEL_W      (SEL_W),
    .CNT_W      (CNT_W),
    .BASE_TICKS (BASE_TICKS)
  ) u_dec (
    .sel_i  (tsel_i),
    .load_o (load)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cyc_i  (cyc_i),
    .ack_i  (ack_i),
    .tick_i (tick),
    .load_i (load),
    .berr_o (berr_o)
  );
endmodule

// File: tb/bus_cycle_wdog_tb_top.sv
module bus_cycle_wdog_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cyc = 1'b0;
  logic       ack = 1'b0;
  logic [2:0] tsel = 3'd0;
  logic       berr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cycle_wdog dut_i (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .tsel_i (tsel),
    .cyc_i (cyc), .ack_i (ack), .berr_o (berr)
  );

  // behavioural reference model
  bit    m_active = 0, m_acked = 0, m_seen = 0, m_prev_cyc = 0, m_rearm = 0;
  bit    tag_r7 = 0;
  int    m_n = 0, m_lim = 0, m_cycles = 0;
  string m_why = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_prev_cyc = 0; m_why = "R1";
    end else begin
      if (cyc && !m_prev_cyc && en) begin
        m_active = 1; m_n = 0; m_lim = 128 << tsel;
        m_acked = 0; m_seen = 0;
        m_rearm = (m_cycles > 0); m_cycles++;
      end else if (!cyc) begin
        m_active = 0; m_why = "R4";
      end else if (!en) begin
        m_active = 0; m_why = "R6";
      end else if (m_active) begin
        m_n++;
        if (ack && !m_seen) m_acked = 1;
      end
      m_prev_cyc = cyc;
    end
  end

  task automatic cmp(input logic exp, input string req);
    checks++;
    if (berr !== exp) begin
      errors++;
      $display("FAIL %s: berr_o=%b expected %b (n=%0d limit=%0d)", req, berr, exp, m_n, m_lim);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n || !m_active) cmp(1'b0, m_why);
      else if (m_acked) cmp(1'b0, "R5");
      else if (m_n < m_lim - 15) begin
        if (m_n == 0 && m_rearm) cmp(1'b0, "R8");
        else if (tag_r7)         cmp(1'b0, "R7");
        else                     cmp(1'b0, "R2");
      end else if (m_n >= m_lim) begin
        cmp(1'b1, "R3");
        m_seen = 1;
      end else begin
        if (m_seen) cmp(1'b1, "R4");
        else if (berr === 1'b1) m_seen = 1;
      end
    end
  end

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic timed(input int s, input int len);
    tsel = 3'(s);
    cyc  = 1'b1;
    idle(len);
    cyc = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    en    = 1'b1;
    idle(3);
    // R2 R3 across selects and prescaler phases
    for (int s = 0; s < 4; s++) begin
      timed(s, (128 << s) + 20);
      idle(s + 1);
    end
    for (int p = 0; p < 4; p++) begin
      timed(0, 150);
      idle(4 * p + 5);
    end
    // R8 back-to-back with one idle clock
    tsel = 3'd0; cyc = 1'b1; idle(140); cyc = 1'b0; idle(1);
    tsel = 3'd1; cyc = 1'b1; idle(280); cyc = 1'b0; idle(3);
    // R5 early acknowledge
    tsel = 3'd0; cyc = 1'b1; idle(30);
    ack = 1'b1; idle(1); ack = 1'b0;
    idle(200); cyc = 1'b0; idle(3);
    // R7 select change mid-cycle
    tsel = 3'd1; cyc = 1'b1; idle(3);
    tag_r7 = 1; tsel = 3'd0; idle(300);
    tag_r7 = 0; cyc = 1'b0; idle(3);
    // R6 disabled cycle, then enable mid-cycle
    en = 1'b0; tsel = 3'd0; cyc = 1'b1; idle(100);
    en = 1'b1; idle(150); cyc = 1'b0; idle(3);
    // R6 enable drop while bus error high
    cyc = 1'b1; idle(150);
    en = 1'b0; idle(5); en = 1'b1; idle(200);
    cyc = 1'b0; idle(3);
    // R3 longest timeout
    timed(7, 16384 + 20);
    idle(5);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule